// File: doc/BRIEF.md
# Pin Select Matrix

The block is a software-programmed crossbar between a chip's pads and its peripherals. Every peripheral input has an input select register. That register feeds the peripheral a constant 0, a constant 1, or the level on one pad. Every pad has an output select register. That register drives the pad low or high, leaves it undriven, or hands it to one peripheral's output and output-enable pair. The low select codes are reserved for the constants and the undriven state. Pad and peripheral numbers therefore appear in the codes with an offset.

Each select register has its own lock bit. A lock bit comes out of reset set. Software can clear it but cannot set it again. While the lock bit is clear, the matching select register keeps its value whatever software writes. Configuration uses a plain write strobe and an address, and reads are combinational. The pad-to-peripheral paths are pure combinational logic controlled by the stored select codes.

The address holds a 2-bit region followed by an entry index. Region 0 holds the input selects, region 1 the input locks, region 2 the output selects and region 3 the output locks. A pad shown as "{oe,out}" means output-enable and output level. An undriven pad shows oe=0 and out=0.

Top module: `pinsel_matrix`

## Requirements
- R1: After reset every input select reads 0 and every output select reads 2. Every lock bit reads 1, every pad shows oe=0, out=0, and every peripheral input is 0.
- R2: Input select code 0 gives the peripheral input a constant 0 and code 1 a constant 1, whatever the pads carry.
- R3: An input select code c with 2 <= c < NUM_PADS+2 forwards pad c-2 to the peripheral input. This includes the last pad, at code NUM_PADS+1.
- R4: An input select code of NUM_PADS+2 or more gives the peripheral input a constant 0.
- R5: Output select code 0 makes the pad show {oe,out} = {1,0}. Code 1 makes it show {1,1}.
- R6: Output select code 2 leaves the pad undriven, showing {0,0}.
- R7: An output select code c with 3 <= c < NUM_PERIPH_OUT+3 passes peripheral output c-3 and its output-enable to the pad. This includes the last peripheral, at code NUM_PERIPH_OUT+2.
- R8: An output select code of NUM_PERIPH_OUT+3 or more leaves the pad undriven, showing {0,0}.
- R9: Writing a lock bit with data bit 0 equal to 0 clears it. Writing 1 to a lock bit has no effect. Only reset sets a lock bit again.
- R10: While an entry's lock bit is 0, a write to its select register leaves the stored code and the routed output unchanged. Other entries stay writable.
- R11: A read returns the stored value zero-extended to 8 bits. Input selects keep the low 6 bits of the write data, output selects keep the low 7 bits, and lock bits read back in bit 0.
- R12: A pad or peripheral value reaches its destination in the same cycle, with no register on the way. A select write takes effect only after the rising clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (5) | Region in the top 2 bits, entry index below |
| cfg_wdata | input | CFG_DW (8) | Write data |
| cfg_rdata | output | CFG_DW (8) | Combinational read data for cfg_addr |
| pad_in | input | NUM_PADS (8) | Levels received from the pads |
| periph_in | output | NUM_PERIPH_IN (6) | Routed peripheral inputs |
| periph_out | input | NUM_PERIPH_OUT (10) | Peripheral output levels |
| periph_oe | input | NUM_PERIPH_OUT (10) | Peripheral output enables |
| pad_out | output | NUM_PADS (8) | Pad output levels |
| pad_oe | output | NUM_PADS (8) | Pad output enables |

## Verification
Pad levels, peripheral outputs and read addresses reach their outputs in the same cycle. The bench changes them half a cycle from an edge and compares one nanosecond later. A select or lock write becomes visible one rising edge after the strobe is raised, so the bench compares at the following falling edge. For R12 it also compares just before that edge, while the old code must still hold. Every expected value is queued by the driver and compared by a separate monitor at the moment it is queued, so no comparison falls on a clock edge.

// File: rtl/pinsel_pkg.sv
package pinsel_pkg;

    // Address regions of the configuration port (top two address bits)
    typedef enum logic [1:0] {
        RGN_IN_SEL   = 2'd0,
        RGN_IN_LOCK  = 2'd1,
        RGN_OUT_SEL  = 2'd2,
        RGN_OUT_LOCK = 2'd3
    } cfg_region_e;

    // Reserved low codes before the first pad / peripheral index
    localparam int unsigned IN_CODE_BASE  = 2;
    localparam int unsigned OUT_CODE_BASE = 3;
    localparam int unsigned OUT_CODE_OFF  = 2;

    // Output drive class decoded from an output select code
    typedef enum logic [1:0] {
        DRV_LOW    = 2'd0,
        DRV_HIGH   = 2'd1,
        DRV_OFF    = 2'd2,
        DRV_PERIPH = 2'd3
    } drive_kind_e;

endpackage

// File: rtl/pinsel_cfg_regs.sv
module pinsel_cfg_regs
    import pinsel_pkg::*;
#(
    parameter int unsigned N_IN  = 6,
    parameter int unsigned N_PAD = 8,
    parameter int unsigned IN_W  = 6,
    parameter int unsigned OUT_W = 7,
    parameter int unsigned IDX_W = 3,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = IDX_W + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    output logic [DW-1:0]               rdata,
    output logic [N_IN-1:0][IN_W-1:0]   in_sel,
    output logic [N_IN-1:0]             in_lock,
    output logic [N_PAD-1:0][OUT_W-1:0] out_sel,
    output logic [N_PAD-1:0]            out_lock
);

    cfg_region_e      rgn;
    logic [IDX_W-1:0] idx;
    logic             wdata_unused;

    assign rgn          = cfg_region_e'(addr[AW-1:AW-2]);
    assign idx          = addr[IDX_W-1:0];
    assign wdata_unused = ^wdata;

    // Input select entries with their lock bits
    for (genvar j = 0; j < N_IN; j++) begin : g_in
        logic hit;
        assign hit = we && (idx == IDX_W'(j));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_sel[j]  <= '0;
                in_lock[j] <= 1'b1;
            end else begin
                if (hit && rgn == RGN_IN_SEL && in_lock[j]) begin
                    in_sel[j] <= wdata[IN_W-1:0];
                end
                if (hit && rgn == RGN_IN_LOCK && !wdata[0]) begin
                    in_lock[j] <= 1'b0;
                end
            end
        end
    end

    // Output select entries with their lock bits
    for (genvar i = 0; i < N_PAD; i++) begin : g_out
        logic hit;
        assign hit = we && (idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_sel[i]  <= OUT_W'(OUT_CODE_OFF);
                out_lock[i] <= 1'b1;
            end else begin
                if (hit && rgn == RGN_OUT_SEL && out_lock[i]) begin
                    out_sel[i] <= wdata[OUT_W-1:0];
                end
                if (hit && rgn == RGN_OUT_LOCK && !wdata[0]) begin
                    out_lock[i] <= 1'b0;
                end
            end
        end
    end

    // Combinational read-back
    always_comb begin
        rdata = '0;
        unique case (rgn)
            RGN_IN_SEL: begin
                for (int k = 0; k < N_IN; k++)
                    if (idx == IDX_W'(k)) rdata = DW'(in_sel[k]);
            end
            RGN_IN_LOCK: begin
                for (int k = 0; k < N_IN; k++)
                    if (idx == IDX_W'(k)) rdata = DW'(in_lock[k]);
            end
            RGN_OUT_SEL: begin
                for (int k = 0; k < N_PAD; k++)
                    if (idx == IDX_W'(k)) rdata = DW'(out_sel[k]);
            end
            RGN_OUT_LOCK: begin
                for (int k = 0; k < N_PAD; k++)
                    if (idx == IDX_W'(k)) rdata = DW'(out_lock[k]);
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/pinsel_in_mux.sv
module pinsel_in_mux
    import pinsel_pkg::*;
#(
    parameter int unsigned N_IN  = 6,
    parameter int unsigned N_PAD = 8,
    parameter int unsigned IN_W  = 6
) (
    input  logic [N_IN-1:0][IN_W-1:0] in_sel,
    input  logic [N_PAD-1:0]          pad_in,
    output logic [N_IN-1:0]           periph_in
);

    for (genvar j = 0; j < N_IN; j++) begin : g_route
        always_comb begin
            periph_in[j] = 1'b0;
            if (in_sel[j] == IN_W'(1)) begin
                periph_in[j] = 1'b1;
            end else begin
                // Codes past the last pad match nothing and stay at 0
                for (int k = 0; k < N_PAD; k++)
                    if (in_sel[j] == IN_W'(k + IN_CODE_BASE)) periph_in[j] = pad_in[k];
            end
        end
    end

endmodule

// File: rtl/pinsel_out_mux.sv
module pinsel_out_mux
    import pinsel_pkg::*;
#(
    parameter int unsigned N_PAD = 8,
    parameter int unsigned N_OUT = 10,
    parameter int unsigned OUT_W = 7
) (
    input  logic [N_PAD-1:0][OUT_W-1:0] out_sel,
    input  logic [N_OUT-1:0]            periph_out,
    input  logic [N_OUT-1:0]            periph_oe,
    output logic [N_PAD-1:0]            pad_out,
    output logic [N_PAD-1:0]            pad_oe
);

    for (genvar i = 0; i < N_PAD; i++) begin : g_drive
        drive_kind_e kind;

        always_comb begin
            if (out_sel[i] == OUT_W'(0))                 kind = DRV_LOW;
            else if (out_sel[i] == OUT_W'(1))            kind = DRV_HIGH;
            else if (out_sel[i] == OUT_W'(OUT_CODE_OFF)) kind = DRV_OFF;
            else                                          kind = DRV_PERIPH;
        end

        always_comb begin
            pad_out[i] = 1'b0;
            pad_oe[i]  = 1'b0;
            unique case (kind)
                DRV_LOW: begin
                    pad_oe[i] = 1'b1;
                end
                DRV_HIGH: begin
                    pad_out[i] = 1'b1;
                    pad_oe[i]  = 1'b1;
                end
                DRV_OFF: begin
                    pad_oe[i] = 1'b0;
                end
                DRV_PERIPH: begin
                    // Codes past the last peripheral match nothing: undriven
                    for (int k = 0; k < N_OUT; k++) begin
                        if (out_sel[i] == OUT_W'(k + OUT_CODE_BASE)) begin
                            pad_out[i] = periph_out[k];
                            pad_oe[i]  = periph_oe[k];
                        end
                    end
                end
                default: pad_oe[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pinsel_matrix.sv
module pinsel_matrix
    import pinsel_pkg::*;
#(
    parameter int unsigned NUM_PADS       = 8,
    parameter int unsigned NUM_PERIPH_IN  = 6,
    parameter int unsigned NUM_PERIPH_OUT = 10,
    parameter int unsigned IN_SEL_W       = 6,
    parameter int unsigned OUT_SEL_W      = 7,
    parameter int unsigned CFG_DW         = 8,
    localparam int unsigned MAX_ENTRIES   = (NUM_PADS > NUM_PERIPH_IN) ? NUM_PADS : NUM_PERIPH_IN,
    localparam int unsigned IDX_W         = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
    localparam int unsigned CFG_AW        = IDX_W + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [CFG_AW-1:0]         cfg_addr,
    input  logic [CFG_DW-1:0]         cfg_wdata,
    output logic [CFG_DW-1:0]         cfg_rdata,
    input  logic [NUM_PADS-1:0]       pad_in,
    output logic [NUM_PERIPH_IN-1:0]  periph_in,
    input  logic [NUM_PERIPH_OUT-1:0] periph_out,
    input  logic [NUM_PERIPH_OUT-1:0] periph_oe,
    output logic [NUM_PADS-1:0]       pad_out,
    output logic [NUM_PADS-1:0]       pad_oe
);

    logic [NUM_PERIPH_IN-1:0][IN_SEL_W-1:0] in_sel_q;
    logic [NUM_PERIPH_IN-1:0]               in_lock_q;
    logic [NUM_PADS-1:0][OUT_SEL_W-1:0]     out_sel_q;
    logic [NUM_PADS-1:0]                    out_lock_q;

    pinsel_cfg_regs #(
        .N_IN  (NUM_PERIPH_IN),
        .N_PAD (NUM_PADS),
        .IN_W  (IN_SEL_W),
        .OUT_W (OUT_SEL_W),
        .IDX_W (IDX_W),
        .DW    (CFG_DW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .in_sel   (in_sel_q),
        .in_lock  (in_lock_q),
        .out_sel  (out_sel_q),
        .out_lock (out_lock_q)
    );

    pinsel_in_mux #(
        .N_IN  (NUM_PERIPH_IN),
        .N_PAD (NUM_PADS),
        .IN_W  (IN_SEL_W)
    ) u_in_mux (
        .in_sel    (in_sel_q),
        .pad_in    (pad_in),
        .periph_in (periph_in)
    );

    pinsel_out_mux #(
        .N_PAD (NUM_PADS),
        .N_OUT (NUM_PERIPH_OUT),
        .OUT_W (OUT_SEL_W)
    ) u_out_mux (
        .out_sel    (out_sel_q),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

endmodule

// File: rtl/pinsel_matrix_chk.sv
module pinsel_matrix_chk #(
    parameter int unsigned NUM_PADS       = 8,
    parameter int unsigned NUM_PERIPH_IN  = 6,
    parameter int unsigned NUM_PERIPH_OUT = 10,
    parameter int unsigned IN_SEL_W       = 6,
    parameter int unsigned OUT_SEL_W      = 7
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic [NUM_PERIPH_IN-1:0][IN_SEL_W-1:0] in_sel,
    input logic [NUM_PERIPH_IN-1:0]               in_lock,
    input logic [NUM_PADS-1:0][OUT_SEL_W-1:0]     out_sel,
    input logic [NUM_PADS-1:0]                    out_lock,
    input logic [NUM_PERIPH_IN-1:0]               periph_in,
    input logic [NUM_PERIPH_OUT-1:0]              periph_out,
    input logic [NUM_PERIPH_OUT-1:0]              periph_oe,
    input logic [NUM_PADS-1:0]                    pad_out,
    input logic [NUM_PADS-1:0]                    pad_oe
);

    // R9
    in_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_lock & ~$past(in_lock)) == '0));

    // R9
    out_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_lock & ~$past(out_lock)) == '0));

    for (genvar j = 0; j < NUM_PERIPH_IN; j++) begin : g_in_chk
        // R10
        in_locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_lock[j] |=> $stable(in_sel[j]));

        // R2
        in_const_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_sel[j] == IN_SEL_W'(1)) |-> periph_in[j]);

        // R2
        in_const_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_sel[j] == '0) |-> !periph_in[j]);

        // R4
        in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_sel[j] >= IN_SEL_W'(NUM_PADS + 2)) |-> !periph_in[j]);
    end

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_out_chk
        // R10
        out_locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !out_lock[i] |=> $stable(out_sel[i]));

        // R6
        out_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_sel[i] == OUT_SEL_W'(2)) |-> (!pad_oe[i] && !pad_out[i]));

        // R8
        out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_sel[i] >= OUT_SEL_W'(NUM_PERIPH_OUT + 3)) |-> (!pad_oe[i] && !pad_out[i]));

        for (genvar k = 0; k < NUM_PERIPH_OUT; k++) begin : g_src
            // R7
            out_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_sel[i] == OUT_SEL_W'(k + 3)) |->
                    (pad_oe[i] == periph_oe[k] && pad_out[i] == periph_out[k]));
        end
    end

endmodule

bind pinsel_matrix pinsel_matrix_chk #(
    .NUM_PADS       (NUM_PADS),
    .NUM_PERIPH_IN  (NUM_PERIPH_IN),
    .NUM_PERIPH_OUT (NUM_PERIPH_OUT),
    .IN_SEL_W       (IN_SEL_W),
    .OUT_SEL_W      (OUT_SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_sel     (in_sel_q),
    .in_lock    (in_lock_q),
    .out_sel    (out_sel_q),
    .out_lock   (out_lock_q),
    .periph_in  (periph_in),
    .periph_out (periph_out),
    .periph_oe  (periph_oe),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
);

// File: tb/pinsel_matrix_test.sv
module pinsel_matrix_test;

    localparam int NP   = 8;
    localparam int NI   = 6;
    localparam int NO   = 10;
    localparam int IW   = 3;
    localparam int AW   = IW + 2;
    localparam int DW   = 8;
    localparam int KRD  = 0;
    localparam int KPIN = 1;
    localparam int KPAD = 2;
    localparam int RIS  = 0;
    localparam int RIL  = 1;
    localparam int ROS  = 2;
    localparam int ROL  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NI-1:0] periph_in;
    logic [NO-1:0] periph_out = '0;
    logic [NO-1:0] periph_oe = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    typedef struct {
        int        kind;
        int        idx;
        logic [7:0] exp;
        string     tag;
    } sb_item_t;

    sb_item_t sb[$];
    event     sb_ev;

    always #5 clk = ~clk;

    pinsel_matrix uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .pad_in     (pad_in),
        .periph_in  (periph_in),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    function automatic logic [AW-1:0] mk_addr(int rgn, int idx);
        return AW'((rgn << IW) | idx);
    endfunction

    // Monitor: pops queued expectations and compares with the outputs
    initial begin
        forever begin
            @(sb_ev);
            while (sb.size() > 0) begin
                sb_item_t it;
                logic [7:0] obs;
                it = sb.pop_front();
                case (it.kind)
                    KRD:     obs = cfg_rdata;
                    KPIN:    obs = {7'b0, periph_in[it.idx]};
                    default: obs = {6'b0, pad_oe[it.idx], pad_out[it.idx]};
                endcase
                vectors++;
                if (obs !== it.exp) begin
                    miscompares++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, obs, it.exp);
                end
            end
        end
    end

    task automatic expect_val(int kind, int idx, logic [7:0] exp, string tag);
        sb_item_t it;
        #1;
        it.kind = kind;
        it.idx  = idx;
        it.exp  = exp;
        it.tag  = tag;
        sb.push_back(it);
        ->sb_ev;
        #1;
    endtask

    task automatic wr(int rgn, int idx, logic [7:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = mk_addr(rgn, idx);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic rd(int rgn, int idx, logic [7:0] exp, string tag);
        cfg_addr = mk_addr(rgn, idx);
        expect_val(KRD, 0, exp, tag);
    endtask

    initial begin
        #150000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int j = 0; j < NI; j++) begin
            rd(RIS, j, 8'h00, "R1 input select reset");
            rd(RIL, j, 8'h01, "R1 input lock reset");
            expect_val(KPIN, j, 8'h00, "R1 periph input reset");
        end
        for (int i = 0; i < NP; i++) begin
            rd(ROS, i, 8'h02, "R1 output select reset");
            rd(ROL, i, 8'h01, "R1 output lock reset");
            expect_val(KPAD, i, 8'h00, "R1 pad undriven reset");
        end

        // R2: constants
        wr(RIS, 0, 8'd1);
        expect_val(KPIN, 0, 8'h01, "R2 code1 const one");
        wr(RIS, 0, 8'd0);
        pad_in = '1;
        expect_val(KPIN, 0, 8'h00, "R2 code0 const zero with pads high");
        pad_in = '0;

        // R3 / R12: pad routing follows in the same cycle
        wr(RIS, 1, 8'd5);
        pad_in = 8'b0000_1000;
        expect_val(KPIN, 1, 8'h01, "R3 pad3 high");
        pad_in = 8'b1111_0111;
        expect_val(KPIN, 1, 8'h00, "R12 pad3 low same cycle");
        wr(RIS, 2, 8'd9);
        pad_in = 8'h80;
        expect_val(KPIN, 2, 8'h01, "R3 last pad");

        // R4: out of range input codes
        wr(RIS, 2, 8'd10);
        pad_in = 8'hFF;
        expect_val(KPIN, 2, 8'h00, "R4 code10 zero");
        wr(RIS, 2, 8'd63);
        expect_val(KPIN, 2, 8'h00, "R4 code63 zero");
        pad_in = '0;

        // R5 / R6: constant drives and high-Z
        wr(ROS, 0, 8'd0);
        expect_val(KPAD, 0, 8'h02, "R5 drive low");
        wr(ROS, 0, 8'd1);
        expect_val(KPAD, 0, 8'h03, "R5 drive high");
        wr(ROS, 0, 8'd2);
        expect_val(KPAD, 0, 8'h00, "R6 undriven");

        // R7: peripheral routing
        wr(ROS, 1, 8'd3);
        periph_out = 10'h001; periph_oe = 10'h001;
        expect_val(KPAD, 1, 8'h03, "R7 periph0 driving high");
        periph_oe = 10'h000;
        expect_val(KPAD, 1, 8'h01, "R7 periph0 oe low");
        wr(ROS, 2, 8'd12);
        periph_out = 10'h200; periph_oe = 10'h200;
        expect_val(KPAD, 2, 8'h03, "R7 last periph");

        // R8: out of range output codes
        periph_out = '1; periph_oe = '1;
        wr(ROS, 2, 8'd13);
        expect_val(KPAD, 2, 8'h00, "R8 code13 undriven");
        wr(ROS, 2, 8'd127);
        expect_val(KPAD, 2, 8'h00, "R8 code127 undriven");
        periph_out = '0; periph_oe = '0;

        // R11: field widths on read-back
        wr(RIS, 3, 8'hC7);
        rd(RIS, 3, 8'h07, "R11 input select 6 bits");
        wr(ROS, 3, 8'hFF);
        rd(ROS, 3, 8'h7F, "R11 output select 7 bits");
        expect_val(KPAD, 3, 8'h00, "R11 code127 pad undriven");

        // R9: lock bit behaviour
        wr(RIL, 4, 8'h01);
        rd(RIL, 4, 8'h01, "R9 write one keeps lock");
        wr(RIL, 4, 8'h00);
        rd(RIL, 4, 8'h00, "R9 write zero clears");
        wr(RIL, 4, 8'h01);
        rd(RIL, 4, 8'h00, "R9 write one does not reset");
        rd(RIL, 5, 8'h01, "R9 neighbour lock untouched");

        // R10: locked entries ignore writes
        wr(RIS, 4, 8'd1);
        rd(RIS, 4, 8'h00, "R10 locked input select unchanged");
        expect_val(KPIN, 4, 8'h00, "R10 locked input route unchanged");
        wr(RIS, 5, 8'd1);
        expect_val(KPIN, 5, 8'h01, "R10 neighbour still writable");
        wr(ROS, 5, 8'd1);
        expect_val(KPAD, 5, 8'h03, "R10 output before lock");
        wr(ROL, 5, 8'h00);
        rd(ROL, 5, 8'h00, "R10 output lock cleared");
        wr(ROS, 5, 8'd0);
        rd(ROS, 5, 8'h01, "R10 locked output select unchanged");
        expect_val(KPAD, 5, 8'h03, "R10 locked pad unchanged");

        // R12: write lands only after the capturing edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = mk_addr(RIS, 0); cfg_wdata = 8'd1;
        expect_val(KPIN, 0, 8'h00, "R12 old value before edge");
        @(negedge clk);
        cfg_we = 1'b0;
        expect_val(KPIN, 0, 8'h01, "R12 new value after edge");

        // R9: only reset restores locks
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(RIL, 4, 8'h01, "R9 reset restores input lock");
        rd(ROL, 5, 8'h01, "R9 reset restores output lock");
        rd(ROS, 5, 8'h02, "R1 output select back to 2");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule